// File: doc/BRIEF.md
# Video Lock and GOB Resynchronizer

This block is the lock controller behind a video stream parser. The parser reports events to it as single-cycle pulses: a picture start code, a group-of-blocks (GOB) start code with its 4-bit number, an invalid codeword, too many coefficients in a macroblock, or a start code that failed to appear where the syntax required one. A boundary flag from the parser says whether a start code is expected in the current cycle. From these events the block decides whether the parser is locked to the stream.

After it reacquires lock, the block checks GOB numbers until two consecutive numbers follow each other in the format's sequence. From then on it ignores the numbers in the stream and counts GOBs itself. Each time lock is regained, it sends the downstream output stage the numbers of the GOBs that were skipped, one per cycle, so that fixed macroblocks can stand in for them. It counts the three decoding faults and the unexpected start codes in a saturating counter. It drives an active-low error line for every lock-loss event, or for framing errors only.

Top module: `vid_lock_ctrl`

## Requirements
- R1: After reset, `vlock`=0, `chk_busy`=0, `gob_cur`=0, `fault_cnt`=0, `err_n`=1 and `fill_valid`=0.
- R2: While unlocked and `hold`=0, a picture start code (`pic_sc`) always acquires lock. A GOB start code with an in-range number acquires lock only if `restart_gob`=1 and no hold has been released since the last acquisition. On the cycle after acquisition, `vlock`=1 and `chk_busy`=1.
- R3: While locked, a pulse on `err_code`, `err_coef` or `err_miss` makes `vlock`=0 on the next cycle and adds one to `fault_cnt`.
- R4: The legal GOB numbers are 1 to 12 when `fmt_qcif`=0, and 1, 3 and 5 when `fmt_qcif`=1. While locked, an out-of-range GOB number drops lock without counting, if it arrives while checking is active or away from a boundary. While unlocked, an out-of-range number is ignored.
- R5: While `chk_busy`=1, a GOB number received at a boundary becomes `gob_cur`. Checking ends when that number is the successor of the previous `gob_cur`. The successor in CIF is g+1, with 12 followed by 1. The successor in QCIF runs 1 to 3 to 5 to 1. After a picture start code, `gob_cur` shows the last GOB of the format, so its successor is 1.
- R6: Once checking has ended, each GOB start at a boundary advances `gob_cur` to its successor whatever number the stream carries. A picture start at a boundary sets `gob_cur` to the format's last GOB.
- R7: While locked, a legal start code with `at_boundary`=0 makes `vlock`=0 for exactly one cycle, adds one to `fault_cnt`, restarts checking and takes the new number as `gob_cur`.
- R8: At every acquisition or resynchronization after the first lock, each GOB from the successor of the old `gob_cur` up to (but not including) the new target is presented on `fill_gob` with `fill_valid`=1, one per cycle, in sequence order. The target of a picture start is GOB 1. A new request replaces a list still in progress.
- R9: `hold`=1 drops lock on the next cycle and keeps the block unlocked. After `hold` is released, only a picture start code restores lock, even when `restart_gob`=1.
- R10: `fault_cnt` stops at CNT_MAX and further faults leave it unchanged.
- R11: `err_n` is low for one cycle after each lock-loss event (R3, R4, R7, R9) and after each `frame_err` pulse. With `err_frame_only`=1, only `frame_err` drives it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt_qcif | input | 1 | 1 = quarter-size picture format, 0 = full CIF |
| restart_gob | input | 1 | 1 = a GOB start code may reacquire lock, 0 = wait for a picture start |
| hold | input | 1 | Forces loss of lock while high |
| err_frame_only | input | 1 | Limits `err_n` to framing errors |
| at_boundary | input | 1 | Parser is at a point where a start code is expected |
| pic_sc | input | 1 | Picture start code found (pulse) |
| gob_sc | input | 1 | GOB start code found (pulse) |
| gob_id | input | 4 | GOB number carried with `gob_sc` |
| err_code | input | 1 | Codeword invalid for its context (pulse) |
| err_coef | input | 1 | Too many coefficients in a macroblock (pulse) |
| err_miss | input | 1 | Expected start code absent (pulse) |
| frame_err | input | 1 | Framing error from the alignment stage (pulse) |
| vlock | output | 1 | Video lock achieved |
| chk_busy | output | 1 | GOB sequence checking active |
| gob_cur | output | 4 | Current GOB number as tracked by the block |
| fault_cnt | output | $clog2(CNT_MAX+1) | Saturating fault count |
| err_n | output | 1 | Active-low error pulse |
| fill_valid | output | 1 | `fill_gob` holds a skipped GOB to replace |
| fill_gob | output | 4 | Number of a GOB to fill with fixed macroblocks |

## Verification
The bench builds the block with CNT_MAX=5, so that a handful of faults drives the counter into saturation, and keeps the default CIF and QCIF GOB counts, so that wrap-around fill lists (11, 12, 1) and the odd-only QCIF sequence are both reachable. The stimulus runs through a reseeded GOB chain, a resynchronization that wraps past the end of the picture, and a range fault both during checking and away from a boundary. It also covers a hold that outlasts a picture start, and a switch to framing-only error reporting.

// File: rtl/vlc_pkg.sv
package vlc_pkg;

  parameter int GOB_W = 4;

  typedef logic [GOB_W-1:0] gob_t;

  typedef enum logic [1:0] {
    LK_HUNT   = 2'd0,
    LK_LOCKED = 2'd1,
    LK_RESYNC = 2'd2
  } lk_state_e;

  // Highest GOB number of the selected picture format.
  function automatic gob_t gob_last(input logic qcif, input int cif_n, input int qcif_n);
    return qcif ? gob_t'(2 * qcif_n - 1) : gob_t'(cif_n);
  endfunction

  // Range check: CIF uses 1..cif_n, QCIF uses the odd numbers 1..2*qcif_n-1.
  function automatic logic gob_legal(input gob_t g, input logic qcif,
                                     input int cif_n, input int qcif_n);
    if (qcif) return g[0] && (int'(g) <= 2 * qcif_n - 1);
    return (g != '0) && (int'(g) <= cif_n);
  endfunction

  // Next GOB in transmission order, wrapping from the last back to 1.
  function automatic gob_t gob_succ(input gob_t g, input logic qcif,
                                    input int cif_n, input int qcif_n);
    if (g == '0 || int'(g) >= int'(gob_last(qcif, cif_n, qcif_n))) return gob_t'(1);
    return qcif ? gob_t'(int'(g) + 2) : gob_t'(int'(g) + 1);
  endfunction

endpackage

// File: rtl/vlc_ctrl.sv
module vlc_ctrl
  import vlc_pkg::*;
#(
  parameter int CIF_GOBS  = 12,
  parameter int QCIF_GOBS = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fmt_qcif,
  input  logic       restart_gob,
  input  logic       hold,
  input  logic       at_boundary,
  input  logic       pic_sc,
  input  logic       gob_sc,
  input  gob_t       gob_id,
  input  logic       err_code,
  input  logic       err_coef,
  input  logic       err_miss,
  output logic       vlock,
  output logic       chk_busy,
  output gob_t       gob_cur,
  output logic       fill_req,
  output gob_t       fill_from,
  output gob_t       fill_to,
  output logic       ev_fault_loss,
  output logic       ev_range_loss,
  output logic       ev_resync,
  output logic       ev_hold_loss
);

  lk_state_e st_q;
  gob_t      last_q;
  logic      chk_q;
  logic      ref_q;
  logic      holdp_q;

  logic      locked;
  logic      fault_any;
  logic      id_ok;
  logic      pic_lk;
  logic      gob_lk;
  logic      acq_hunt;
  gob_t      tgt;
  gob_t      succ_last;
  gob_t      fmt_last;

  always_comb begin
    locked        = (st_q == LK_LOCKED);
    fault_any     = err_code | err_coef | err_miss;
    id_ok         = gob_legal(gob_id, fmt_qcif, CIF_GOBS, QCIF_GOBS);
    fmt_last      = gob_last(fmt_qcif, CIF_GOBS, QCIF_GOBS);
    succ_last     = gob_succ(last_q, fmt_qcif, CIF_GOBS, QCIF_GOBS);

    ev_hold_loss  = hold & locked;
    ev_fault_loss = ~hold & locked & fault_any;
    pic_lk        = ~hold & locked & ~fault_any & pic_sc;
    gob_lk        = ~hold & locked & ~fault_any & ~pic_sc & gob_sc;
    ev_range_loss = gob_lk & ~id_ok & (chk_q | ~at_boundary);
    ev_resync     = ~at_boundary & (pic_lk | (gob_lk & id_ok));

    acq_hunt      = (st_q == LK_HUNT) & ~hold &
                    (pic_sc | (gob_sc & id_ok & restart_gob & ~holdp_q));

    tgt           = pic_sc ? gob_t'(1) : gob_id;
    fill_req      = (acq_hunt | ev_resync) & ref_q & (succ_last != tgt);
    fill_from     = succ_last;
    fill_to       = tgt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= LK_HUNT;
      last_q  <= '0;
      chk_q   <= 1'b0;
      ref_q   <= 1'b0;
      holdp_q <= 1'b0;
    end else if (hold) begin
      st_q    <= LK_HUNT;
      chk_q   <= 1'b0;
      holdp_q <= 1'b1;
    end else begin
      unique case (st_q)
        LK_HUNT: begin
          if (acq_hunt) begin
            st_q    <= LK_LOCKED;
            chk_q   <= 1'b1;
            ref_q   <= 1'b1;
            holdp_q <= 1'b0;
            last_q  <= pic_sc ? fmt_last : gob_id;
          end
        end
        LK_RESYNC: st_q <= LK_LOCKED;
        default: begin
          if (ev_fault_loss || ev_range_loss) begin
            st_q  <= LK_HUNT;
            chk_q <= 1'b0;
          end else if (ev_resync) begin
            st_q   <= LK_RESYNC;
            chk_q  <= 1'b1;
            last_q <= pic_sc ? fmt_last : gob_id;
          end else if (pic_lk) begin
            last_q <= fmt_last;
          end else if (gob_lk) begin
            if (chk_q) begin
              last_q <= gob_id;
              if (gob_id == succ_last) chk_q <= 1'b0;
            end else begin
              last_q <= succ_last;
            end
          end
        end
      endcase
    end
  end

  assign vlock    = locked;
  assign chk_busy = chk_q;
  assign gob_cur  = last_q;

endmodule

// File: rtl/vlc_fill.sv
module vlc_fill
  import vlc_pkg::*;
#(
  parameter int CIF_GOBS  = 12,
  parameter int QCIF_GOBS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fmt_qcif,
  input  logic fill_req,
  input  gob_t fill_from,
  input  gob_t fill_to,
  output logic fill_valid,
  output gob_t fill_gob
);

  logic busy_q;
  gob_t pos_q;
  gob_t stop_q;
  gob_t nxt;

  assign nxt = gob_succ(pos_q, fmt_qcif, CIF_GOBS, QCIF_GOBS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      pos_q  <= '0;
      stop_q <= '0;
    end else if (fill_req) begin
      busy_q <= 1'b1;
      pos_q  <= fill_from;
      stop_q <= fill_to;
    end else if (busy_q) begin
      pos_q  <= nxt;
      busy_q <= (nxt != stop_q);
    end
  end

  assign fill_valid = busy_q;
  assign fill_gob   = pos_q;

endmodule

// File: rtl/vlc_faults.sv
module vlc_faults #(
  parameter int CNT_MAX = 256,
  localparam int CNT_W  = $clog2(CNT_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             err_frame_only,
  input  logic             frame_err,
  input  logic             ev_fault_loss,
  input  logic             ev_range_loss,
  input  logic             ev_resync,
  input  logic             ev_hold_loss,
  output logic [CNT_W-1:0] fault_cnt,
  output logic             err_n
);

  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(CNT_MAX);

  logic [CNT_W-1:0] cnt_q;
  logic             err_q;
  logic             bump;
  logic             any_loss;

  assign bump     = ev_fault_loss | ev_resync;
  assign any_loss = ev_fault_loss | ev_range_loss | ev_resync | ev_hold_loss;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      err_q <= 1'b1;
    end else begin
      if (bump && cnt_q != CNT_TOP) cnt_q <= cnt_q + 1'b1;
      err_q <= ~(frame_err | (~err_frame_only & any_loss));
    end
  end

  assign fault_cnt = cnt_q;
  assign err_n     = err_q;

endmodule

// File: rtl/vid_lock_ctrl.sv
module vid_lock_ctrl #(
  parameter int CNT_MAX   = 256,
  parameter int CIF_GOBS  = 12,
  parameter int QCIF_GOBS = 3,
  localparam int CNT_W    = $clog2(CNT_MAX + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      fmt_qcif,
  input  logic                      restart_gob,
  input  logic                      hold,
  input  logic                      err_frame_only,
  input  logic                      at_boundary,
  input  logic                      pic_sc,
  input  logic                      gob_sc,
  input  logic [vlc_pkg::GOB_W-1:0] gob_id,
  input  logic                      err_code,
  input  logic                      err_coef,
  input  logic                      err_miss,
  input  logic                      frame_err,
  output logic                      vlock,
  output logic                      chk_busy,
  output logic [vlc_pkg::GOB_W-1:0] gob_cur,
  output logic [CNT_W-1:0]          fault_cnt,
  output logic                      err_n,
  output logic                      fill_valid,
  output logic [vlc_pkg::GOB_W-1:0] fill_gob
);

  // Named internal events, also observed by the bound checker.
  logic                      ev_fault_loss;
  logic                      ev_range_loss;
  logic                      ev_resync;
  logic                      ev_hold_loss;
  logic                      fill_req;
  logic [vlc_pkg::GOB_W-1:0] fill_from;
  logic [vlc_pkg::GOB_W-1:0] fill_to;

  vlc_ctrl #(.CIF_GOBS(CIF_GOBS), .QCIF_GOBS(QCIF_GOBS)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .fmt_qcif     (fmt_qcif),
    .restart_gob  (restart_gob),
    .hold         (hold),
    .at_boundary  (at_boundary),
    .pic_sc       (pic_sc),
    .gob_sc       (gob_sc),
    .gob_id       (gob_id),
    .err_code     (err_code),
    .err_coef     (err_coef),
    .err_miss     (err_miss),
    .vlock        (vlock),
    .chk_busy     (chk_busy),
    .gob_cur      (gob_cur),
    .fill_req     (fill_req),
    .fill_from    (fill_from),
    .fill_to      (fill_to),
    .ev_fault_loss(ev_fault_loss),
    .ev_range_loss(ev_range_loss),
    .ev_resync    (ev_resync),
    .ev_hold_loss (ev_hold_loss)
  );

  vlc_fill #(.CIF_GOBS(CIF_GOBS), .QCIF_GOBS(QCIF_GOBS)) u_fill (
    .clk       (clk),
    .rst_n     (rst_n),
    .fmt_qcif  (fmt_qcif),
    .fill_req  (fill_req),
    .fill_from (fill_from),
    .fill_to   (fill_to),
    .fill_valid(fill_valid),
    .fill_gob  (fill_gob)
  );

  vlc_faults #(.CNT_MAX(CNT_MAX)) u_faults (
    .clk           (clk),
    .rst_n         (rst_n),
    .err_frame_only(err_frame_only),
    .frame_err     (frame_err),
    .ev_fault_loss (ev_fault_loss),
    .ev_range_loss (ev_range_loss),
    .ev_resync     (ev_resync),
    .ev_hold_loss  (ev_hold_loss),
    .fault_cnt     (fault_cnt),
    .err_n         (err_n)
  );

endmodule

// File: rtl/vid_lock_chk.sv
module vid_lock_chk #(
  parameter int CNT_MAX   = 256,
  parameter int CIF_GOBS  = 12,
  parameter int QCIF_GOBS = 3,
  localparam int CNT_W    = $clog2(CNT_MAX + 1)
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      hold,
  input logic                      pic_sc,
  input logic                      fmt_qcif,
  input logic                      frame_err,
  input logic                      err_frame_only,
  input logic                      vlock,
  input logic                      chk_busy,
  input logic [CNT_W-1:0]          fault_cnt,
  input logic                      err_n,
  input logic                      fill_valid,
  input logic [vlc_pkg::GOB_W-1:0] fill_gob,
  input logic                      ev_fault_loss,
  input logic                      ev_range_loss,
  input logic                      ev_resync,
  input logic                      ev_hold_loss
);

  p_pic_acq_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!vlock && !chk_busy && !hold && pic_sc) |=> (vlock && chk_busy));

  p_fault_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fault_loss |=> !vlock);

  p_range_nocount_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_range_loss |=> (!vlock && fault_cnt == $past(fault_cnt)));

  p_resync_dip_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_resync |=> (!vlock && chk_busy));

  p_resync_back_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ev_resync) && !hold) |=> vlock);

  p_fill_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |-> vlc_pkg::gob_legal(fill_gob, fmt_qcif, CIF_GOBS, QCIF_GOBS));

  p_hold_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hold_loss |=> !vlock);

  p_cnt_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fault_cnt) |-> (fault_cnt == $past(fault_cnt) + 1'b1));

  p_cnt_sat_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_fault_loss && fault_cnt == CNT_W'(CNT_MAX)) |=> (fault_cnt == CNT_W'(CNT_MAX)));

  p_err_mode_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!err_n && $past(err_frame_only)) |-> $past(frame_err));

endmodule

bind vid_lock_ctrl vid_lock_chk #(
  .CNT_MAX  (CNT_MAX),
  .CIF_GOBS (CIF_GOBS),
  .QCIF_GOBS(QCIF_GOBS)
) u_chk (.*);

// File: tb/vid_lock_ctrl_bench.sv
module vid_lock_ctrl_bench;

  localparam int BCNT  = 5;
  localparam int CW    = $clog2(BCNT + 1);
  localparam int NCIF  = 12;
  localparam int NQCIF = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fmt_qcif = 1'b0, restart_gob = 1'b0, hold = 1'b0, err_frame_only = 1'b0;
  logic at_boundary = 1'b1, pic_sc = 1'b0, gob_sc = 1'b0;
  logic [3:0] gob_id = 4'd0;
  logic err_code = 1'b0, err_coef = 1'b0, err_miss = 1'b0, frame_err = 1'b0;
  logic vlock, chk_busy, err_n, fill_valid;
  logic [3:0] gob_cur, fill_gob;
  logic [CW-1:0] fault_cnt;

  always #2 clk = ~clk;

  vid_lock_ctrl #(.CNT_MAX(BCNT), .CIF_GOBS(NCIF), .QCIF_GOBS(NQCIF)) u_vid_lock_ctrl (
    .clk(clk), .rst_n(rst_n), .fmt_qcif(fmt_qcif), .restart_gob(restart_gob),
    .hold(hold), .err_frame_only(err_frame_only), .at_boundary(at_boundary),
    .pic_sc(pic_sc), .gob_sc(gob_sc), .gob_id(gob_id), .err_code(err_code),
    .err_coef(err_coef), .err_miss(err_miss), .frame_err(frame_err),
    .vlock(vlock), .chk_busy(chk_busy), .gob_cur(gob_cur), .fault_cnt(fault_cnt),
    .err_n(err_n), .fill_valid(fill_valid), .fill_gob(fill_gob)
  );

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_mode = 0;          // 0 searching, 1 locked, 2 one-cycle dip
  int m_last = 0;
  bit m_chk = 0, m_seen = 0, m_held = 0, m_errn = 1;
  int m_cnt = 0;
  int m_fill[$];

  function automatic int fmt_top();
    return fmt_qcif ? 2 * NQCIF - 1 : NCIF;
  endfunction

  function automatic bit in_range(int g);
    if (fmt_qcif) return (g % 2 == 1) && g <= 2 * NQCIF - 1;
    return g >= 1 && g <= NCIF;
  endfunction

  function automatic int after(int g);
    if (g <= 0 || g >= fmt_top()) return 1;
    return fmt_qcif ? g + 2 : g + 1;
  endfunction

  task automatic bump();
    if (m_cnt < BCNT) m_cnt++;
  endtask

  // Returns 1 when a new fill list was built.
  function automatic bit plan_fill(int target);
    int g;
    if (!m_seen || after(m_last) == target) return 0;
    m_fill.delete();
    g = after(m_last);
    while (g != target) begin
      m_fill.push_back(g);
      g = after(g);
    end
    return 1;
  endfunction

  always @(posedge clk) begin
    bit lost, fresh;
    lost = 0;
    fresh = 0;
    if (!rst_n) begin
      m_mode = 0; m_last = 0; m_chk = 0; m_seen = 0; m_held = 0;
      m_errn = 1; m_cnt = 0; m_fill.delete();
    end else begin
      if (hold) begin
        if (m_mode == 1) lost = 1;
        m_mode = 0; m_chk = 0; m_held = 1;
      end else if (m_mode == 2) begin
        m_mode = 1;
      end else if (m_mode == 0) begin
        if (pic_sc || (gob_sc && restart_gob && !m_held && in_range(int'(gob_id)))) begin
          fresh = plan_fill(pic_sc ? 1 : int'(gob_id));
          m_last = pic_sc ? fmt_top() : int'(gob_id);
          m_mode = 1; m_chk = 1; m_seen = 1; m_held = 0;
        end
      end else if (err_code || err_coef || err_miss) begin
        lost = 1; bump(); m_mode = 0; m_chk = 0;
      end else if (pic_sc) begin
        if (!at_boundary) begin
          lost = 1; bump(); fresh = plan_fill(1);
          m_last = fmt_top(); m_mode = 2; m_chk = 1;
        end else m_last = fmt_top();
      end else if (gob_sc) begin
        if (!in_range(int'(gob_id)) && (m_chk || !at_boundary)) begin
          lost = 1; m_mode = 0; m_chk = 0;
        end else if (!at_boundary) begin
          lost = 1; bump(); fresh = plan_fill(int'(gob_id));
          m_last = int'(gob_id); m_mode = 2; m_chk = 1;
        end else if (m_chk) begin
          if (int'(gob_id) == after(m_last)) m_chk = 0;
          m_last = int'(gob_id);
        end else m_last = after(m_last);
      end
      if (!fresh && m_fill.size() > 0) void'(m_fill.pop_front());
      m_errn = !(frame_err || (!err_frame_only && lost));
    end
  end

  // Compare every output against the model on each falling edge.
  always @(negedge clk) begin
    check("R2 R3 R7 R9 vlock", 16'(vlock), 16'(m_mode == 1));
    check("R5 chk_busy", 16'(chk_busy), 16'(m_chk));
    check("R5 R6 gob_cur", 16'(gob_cur), 16'(m_last));
    check("R10 fault_cnt", 16'(fault_cnt), 16'(m_cnt));
    check("R11 err_n", 16'(err_n), 16'(m_errn));
    check("R8 fill_valid", 16'(fill_valid), 16'(m_fill.size() > 0));
    if (m_fill.size() > 0) check("R8 fill_gob", 16'(fill_gob), 16'(m_fill[0]));
  end

  // ---------------- stimulus ----------------
  task automatic step();
    @(posedge clk);
    #1;
    pic_sc = 0; gob_sc = 0; err_code = 0; err_coef = 0; err_miss = 0;
    frame_err = 0; at_boundary = 1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic send_gob(input int n, input bit bnd);
    gob_sc = 1; gob_id = 4'(n); at_boundary = bnd;
    step();
  endtask

  task automatic send_pic(input bit bnd);
    pic_sc = 1; at_boundary = bnd;
    step();
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    @(negedge clk);
    check("R1 reset vlock", 16'(vlock), 0);
    check("R1 reset err_n", 16'(err_n), 1);
    check("R1 reset cnt", 16'(fault_cnt), 0);
    check("R1 reset fill", 16'(fill_valid), 0);
    rst_n = 1;
    idle(2);

    send_gob(3, 1);                    // R2: GOB code ignored when restart_gob=0
    @(negedge clk); check("R2 gob ignored", 16'(vlock), 0);
    send_pic(1);
    @(negedge clk); check("R2 pic acquires", 16'(vlock), 1);
    check("R5 after pic gob_cur", 16'(gob_cur), 12);
    send_gob(1, 1);
    @(negedge clk); check("R5 chain ends", 16'(chk_busy), 0);
    send_gob(9, 1); send_gob(9, 1);
    @(negedge clk); check("R6 internal numbering", 16'(gob_cur), 3);

    err_code = 1; step();
    @(negedge clk); check("R3 drop", 16'(vlock), 0);
    check("R3 count", 16'(fault_cnt), 1);
    check("R11 err pulse", 16'(err_n), 0);
    idle(1);
    restart_gob = 1;
    send_gob(7, 1);
    @(negedge clk); check("R8 first fill", 16'(fill_gob), 4);
    check("R8 fill valid", 16'(fill_valid), 1);
    idle(3);
    send_gob(9, 1);
    @(negedge clk); check("R5 reseed", 16'(chk_busy), 1);
    send_gob(10, 1);
    @(negedge clk); check("R5 sequential", 16'(chk_busy), 0);

    send_gob(2, 0);                    // R7: unexpected start, wraps fill 11,12,1
    @(negedge clk); check("R7 dip", 16'(vlock), 0);
    check("R7 count", 16'(fault_cnt), 2);
    check("R8 wrap fill", 16'(fill_gob), 11);
    idle(1);
    @(negedge clk); check("R7 relock", 16'(vlock), 1);
    idle(3);
    send_gob(3, 1);
    send_gob(14, 0);                   // R4: out of range away from boundary
    @(negedge clk); check("R4 range drop", 16'(vlock), 0);
    check("R4 no count", 16'(fault_cnt), 2);
    send_gob(13, 1);
    @(negedge clk); check("R4 hunt ignores", 16'(vlock), 0);
    send_gob(5, 1);
    idle(1);
    send_gob(15, 1);                   // R4: out of range while checking
    @(negedge clk); check("R4 chk range drop", 16'(vlock), 0);

    send_gob(6, 1);
    hold = 1; step();
    @(negedge clk); check("R9 hold drop", 16'(vlock), 0);
    send_pic(1);
    @(negedge clk); check("R9 held", 16'(vlock), 0);
    hold = 0;
    send_gob(8, 1);
    @(negedge clk); check("R9 gob not enough", 16'(vlock), 0);
    send_pic(1);
    @(negedge clk); check("R9 pic relocks", 16'(vlock), 1);
    idle(7);

    err_frame_only = 1;
    frame_err = 1; step();
    @(negedge clk); check("R11 framing only", 16'(err_n), 0);
    err_coef = 1; step();
    @(negedge clk); check("R11 fault masked", 16'(err_n), 1);
    check("R3 coef count", 16'(fault_cnt), 3);
    err_frame_only = 0;
    idle(1);

    send_gob(1, 1); err_miss = 1; step();
    send_gob(2, 1); err_miss = 1; step();
    @(negedge clk); check("R10 reach max", 16'(fault_cnt), 5);
    send_gob(3, 1); err_miss = 1; step();
    @(negedge clk); check("R10 saturated", 16'(fault_cnt), 5);
    send_gob(4, 1); send_gob(6, 0);
    @(negedge clk); check("R10 resync saturated", 16'(fault_cnt), 5);
    idle(3);
    err_code = 1; step();

    fmt_qcif = 1;
    idle(1);
    send_pic(1);
    @(negedge clk); check("R5 qcif last", 16'(gob_cur), 5);
    send_gob(1, 1); send_gob(7, 1);
    @(negedge clk); check("R6 qcif step", 16'(gob_cur), 3);
    err_coef = 1; step();
    send_gob(5, 1);
    err_code = 1; step();
    send_gob(3, 1);
    @(negedge clk); check("R8 qcif fill", 16'(fill_gob), 1);
    send_gob(2, 1);
    @(negedge clk); check("R4 qcif even", 16'(vlock), 0);
    idle(4);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule